// File: doc/BRIEF.md
# Port Mirroring Mask Generator

This block is the last mask stage of a small switch's forwarding path. For every frame it takes the ingress port number, the destination mask produced by the address lookup and a per-port mirroring configuration, and produces the egress mask that is handed to the frame replication logic. When the mirroring rules call for it, the sniffer port is added to the mask so that a monitoring device receives a copy of the frame.

Each port has one small configuration word with three bits. One bit marks the port for mirroring of the traffic it receives. One marks it for mirroring of the traffic it transmits. One makes it the sniffer. The two mirroring kinds are chosen independently, may be combined on different ports or the same port, and may be set on several ports at once. Any port can be made the sniffer. The result is registered, so the egress mask appears one clock after the frame's request.

Top module: `mirror_mask_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `out_mask` is all zeros.
- R2: A request presented with `in_valid` high produces `out_valid` high with its mask exactly one clock later. A cycle with `in_valid` low produces `out_valid` low and `out_mask` all zeros one clock later.
- R3: Every bit set in `in_dest_mask` is also set in the resulting `out_mask`. No bit other than the chosen sniffer port is ever added.
- R4: If the ingress port's receive-mirror bit (`cfg_bits[3*p+0]`) is set, the sniffer port is added to the mask.
- R5: If any port set in `in_dest_mask` has its transmit-mirror bit (`cfg_bits[3*p+1]`) set, the sniffer port is added to the mask.
- R6: When both the receive rule and the transmit rule match, possibly through several marked ports, the sniffer port is added once. At most one bit beyond the lookup mask is ever set.
- R7: Any port may be the sniffer (`cfg_bits[3*p+2]`). If several ports are marked, the lowest-numbered one is used.
- R8: A mirror copy is never added on the frame's own ingress port. If the sniffer is the ingress port, the lookup mask passes unchanged.
- R9: With no sniffer bit set on any port, `out_mask` equals `in_dest_mask`, whatever the mirror bits are.
- R10: If neither rule matches, no bit is added, even if other ports carry mirror bits. An `in_port` value of NPORTS or more never matches the receive rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A frame's mask request is present |
| in_port | input | PW = clog2(NPORTS) | Ingress port number of the frame |
| in_dest_mask | input | NPORTS | Destination mask from the address lookup |
| cfg_bits | input | 3*NPORTS | Per-port mirroring word: bit 0 receive-mirror, bit 1 transmit-mirror, bit 2 sniffer |
| out_valid | output | 1 | Registered result is present |
| out_mask | output | NPORTS | Final egress mask including any mirror copy |

## Verification
The receive rule and the transmit rule can both fire for the same frame in the same cycle. When they do, the two copies they request must merge into a single sniffer bit. The bench provokes this by marking the ingress port for receive mirroring and a destination port for transmit mirroring together. It also relies on long stretches of random configuration and destinations, where both matches occur often. Each cycle the outputs are compared with a behavioural model, which also covers the clash between a mirror copy and the ingress-port exclusion: it checks that the added bit never lands on the ingress port and never counts twice.

// File: rtl/mirror_pkg.sv
// Package: shared layout of the per-port mirroring configuration word.
// Assumes every port's word is CFG_W bits wide and packed port 0 first.
package mirror_pkg;
    localparam int CFG_W      = 3;
    localparam int CFG_RX_BIT = 0;  // mirror what this port receives
    localparam int CFG_TX_BIT = 1;  // mirror what this port transmits
    localparam int CFG_SN_BIT = 2;  // this port is a sniffer candidate
endpackage

// File: rtl/mm_sniffer_pick.sv
// Module: picks one sniffer port out of the candidate vector.
// The lowest-numbered marked port wins. The output is one-hot or zero.
// Assumes the candidates are stable for the cycle; purely combinational.
module mm_sniffer_pick #(
    parameter int NPORTS = 4
) (
    input  logic [NPORTS-1:0] cand,
    output logic [NPORTS-1:0] pick,
    output logic              any
);
    logic [NPORTS:0] seen;

    assign seen[0] = 1'b0;

    // Priority chain: a port is picked only if no lower port was marked.
    for (genvar i = 0; i < NPORTS; i++) begin : g_chain
        assign pick[i]   = cand[i] & ~seen[i];
        assign seen[i+1] = seen[i] | cand[i];
    end

    assign any = seen[NPORTS];
endmodule

// File: rtl/mm_rule_match.sv
// Module: evaluates the receive and transmit mirroring rules for one frame.
// It also decodes the ingress port to one-hot. A port number of NPORTS or
// more decodes to zero and never matches. Purely combinational.
module mm_rule_match #(
    parameter int NPORTS = 4,
    parameter int PW     = 2
) (
    input  logic [PW-1:0]     port,
    input  logic [NPORTS-1:0] dest,
    input  logic [NPORTS-1:0] rx_mark,
    input  logic [NPORTS-1:0] tx_mark,
    output logic [NPORTS-1:0] ing_oh,
    output logic              rx_hit,
    output logic              tx_hit
);
    // Ingress decode: one comparator per port.
    for (genvar i = 0; i < NPORTS; i++) begin : g_dec
        assign ing_oh[i] = (32'(port) == i);
    end

    // Receive rule looks only at the ingress port; transmit rule at all destinations.
    assign rx_hit = |(ing_oh & rx_mark);
    assign tx_hit = |(dest & tx_mark);
endmodule

// File: rtl/mirror_mask_gen.sv
// Module: final egress mask stage with port mirroring, one register deep.
// Unpacks the per-port configuration words, evaluates both mirror rules and
// picks the sniffer. It adds the sniffer to the lookup mask unless the
// sniffer is the ingress port.
// Assumes the configuration is quasi-static and is sampled with the request.
module mirror_mask_gen
    import mirror_pkg::*;
#(
    parameter  int NPORTS = 4,
    localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int CW     = NPORTS * CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PW-1:0]     in_port,
    input  logic [NPORTS-1:0] in_dest_mask,
    input  logic [CW-1:0]     cfg_bits,
    output logic              out_valid,
    output logic [NPORTS-1:0] out_mask
);
    logic [NPORTS-1:0] rx_mark, tx_mark, sn_mark;
    logic [NPORTS-1:0] ing_oh, sn_pick, add_mask, next_mask;
    logic              rx_hit, tx_hit, sn_any, mirror;

    // Configuration unpack: one word per port, fields from the package.
    for (genvar p = 0; p < NPORTS; p++) begin : g_cfg
        assign rx_mark[p] = cfg_bits[p*CFG_W + CFG_RX_BIT];
        assign tx_mark[p] = cfg_bits[p*CFG_W + CFG_TX_BIT];
        assign sn_mark[p] = cfg_bits[p*CFG_W + CFG_SN_BIT];
    end

    mm_rule_match #(.NPORTS(NPORTS), .PW(PW)) u_match (
        .port    (in_port),
        .dest    (in_dest_mask),
        .rx_mark (rx_mark),
        .tx_mark (tx_mark),
        .ing_oh  (ing_oh),
        .rx_hit  (rx_hit),
        .tx_hit  (tx_hit)
    );

    mm_sniffer_pick #(.NPORTS(NPORTS)) u_pick (
        .cand (sn_mark),
        .pick (sn_pick),
        .any  (sn_any)
    );

    // Mask merge: one shared sniffer bit, never on the ingress port.
    always_comb begin
        mirror    = (rx_hit | tx_hit) & sn_any;
        add_mask  = mirror ? (sn_pick & ~ing_oh) : '0;
        next_mask = in_dest_mask | add_mask;
    end

    // Output register: result valid one clock after the request, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else begin
            out_valid <= in_valid;
            out_mask  <= in_valid ? next_mask : '0;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_mask == '0));  // R2
    AST_LOOKUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_mask & $past(in_dest_mask)) == $past(in_dest_mask)));  // R3
    AST_SINGLE_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $onehot0(out_mask & ~$past(in_dest_mask)));  // R6
    AST_EXTRA_IS_SNIFFER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_mask & ~$past(in_dest_mask) & ~$past(sn_pick)) == '0));  // R7
    AST_NO_INGRESS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_mask & ~$past(in_dest_mask) & $past(ing_oh)) == '0));  // R8
    AST_NO_SNIFFER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sn_mark == '0) |=> (out_mask == $past(in_dest_mask)));  // R9
    AST_NO_RULE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rx_hit && !tx_hit) |=> (out_mask == $past(in_dest_mask)));  // R10
endmodule

// File: tb/tb_mirror_mask_gen.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module tb_mirror_mask_gen;
    localparam int NP = 4;
    localparam int PW = 2;
    localparam int CW = 3 * NP;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [PW-1:0] in_port;
    logic [NP-1:0] in_dest_mask;
    logic [CW-1:0] cfg_bits;
    logic          out_valid;
    logic [NP-1:0] out_mask;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #4 clk = ~clk;  // 125 MHz

    mirror_mask_gen #(.NPORTS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .in_dest_mask(in_dest_mask), .cfg_bits(cfg_bits),
        .out_valid(out_valid), .out_mask(out_mask)
    );

    // Build a configuration from three per-port vectors.
    function automatic logic [CW-1:0] mk_cfg(logic [NP-1:0] rx, logic [NP-1:0] tx,
                                             logic [NP-1:0] sn);
        logic [CW-1:0] c = '0;
        for (int p = 0; p < NP; p++) begin
            c[3*p]   = rx[p];
            c[3*p+1] = tx[p];
            c[3*p+2] = sn[p];
        end
        return c;
    endfunction

    // Reference: rules evaluated behaviourally with integers.
    function automatic logic [NP-1:0] model(int port, logic [NP-1:0] dest, logic [CW-1:0] c);
        int            sn  = -1;
        bit            hit = 0;
        logic [NP-1:0] r   = dest;
        for (int p = NP - 1; p >= 0; p--) if (c[3*p+2]) sn = p;
        if (port < NP && c[3*port]) hit = 1;
        for (int p = 0; p < NP; p++) if (dest[p] && c[3*p+1]) hit = 1;
        if (hit && sn >= 0 && sn != port) r[sn] = 1'b1;
        return r;
    endfunction

    task automatic check(string tag, logic ev, logic [NP-1:0] em);
        total++;
        if (out_valid !== ev || out_mask !== em) begin
            bad++;
            $display("FAIL %s: got valid=%0b mask=%b, expected valid=%0b mask=%b",
                     tag, out_valid, out_mask, ev, em);
        end
    endtask

    // Drive one request at a falling edge, compare one clock later.
    task automatic step(string tag, logic v, int port, logic [NP-1:0] dest, logic [CW-1:0] c);
        logic [NP-1:0] em;
        in_valid     = v;
        in_port      = PW'(port);
        in_dest_mask = dest;
        cfg_bits     = c;
        em = v ? model(port, dest, c) : '0;
        @(negedge clk);
        check(tag, v, em);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_port = '0;
        in_dest_mask = '1; cfg_bits = mk_cfg(4'b1111, 4'b1111, 4'b0001);
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, '0);

        step("R9 no sniffer", 1, 1, 4'b0100, mk_cfg(4'b1111, 4'b1111, 4'b0000));
        step("R4 rx mirror", 1, 1, 4'b0001, mk_cfg(4'b0010, 4'b0000, 4'b1000));
        step("R10 other port rx", 1, 2, 4'b0001, mk_cfg(4'b0010, 4'b0000, 4'b1000));
        step("R5 tx mirror", 1, 3, 4'b0100, mk_cfg(4'b0000, 4'b0100, 4'b0001));
        step("R6 both rules", 1, 1, 4'b0100, mk_cfg(4'b0010, 4'b0100, 4'b1000));
        step("R6 many marks", 1, 0, 4'b0110, mk_cfg(4'b1111, 4'b0110, 4'b1000));
        step("R7 lowest sniffer", 1, 0, 4'b1000, mk_cfg(4'b0001, 4'b0000, 4'b0110));
        step("R7 port0 sniffer", 1, 1, 4'b0100, mk_cfg(4'b0010, 4'b0000, 4'b0001));
        step("R8 rx ingress", 1, 2, 4'b0001, mk_cfg(4'b0100, 4'b0000, 4'b0100));
        step("R8 tx ingress", 1, 1, 4'b0001, mk_cfg(4'b0000, 4'b0001, 4'b0010));
        step("R3 empty lookup", 1, 1, 4'b0000, mk_cfg(4'b0010, 4'b0000, 4'b1000));
        step("R3 sniffer in lookup", 1, 0, 4'b1010, mk_cfg(4'b0001, 4'b0000, 4'b1000));
        step("R2 idle cycle", 0, 1, 4'b0001, mk_cfg(4'b0010, 4'b0000, 4'b1000));
        step("R2 back to back", 1, 3, 4'b0011, mk_cfg(4'b0000, 4'b0010, 4'b0100));

        for (int k = 0; k < 600; k++) begin
            step("R6 random", ($urandom_range(0, 7) != 0), int'($urandom_range(0, NP - 1)),
                 NP'($urandom), CW'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule